// File: doc/BRIEF.md
# USB Endpoint Status and Handshake Control

This block holds the 8-bit status and control word of one USB device endpoint. It also chooses the handshake that the endpoint returns to the current token. Software reads the word and writes it through a simple byte port with a write strobe. The serial engine reports what happened on the wire through one-cycle event strobes. Hardware sets and clears the flags from those events. The rules depend on whether the endpoint is isochronous.

The block drives three outputs:
- the handshake for the token kind presented on `tok_kind`;
- an IN-data-available level;
- the endpoint interrupt request.

FIFO storage, CRC generation and bit serialisation are handled elsewhere.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset `rd_data` is 8'h00. The word layout, from bit 7 down to bit 0, is: direction, reserved, stall request, transmit ready, stall-sent/CRC flag, setup flag, OUT flag, transmit-done flag. `ep_type` encodes 00 control, 01 bulk, 10 interrupt and 11 isochronous.
- R2: Bit 6 always reads 0, and writing 1 to it has no effect. Bits 7, 5 and 4 take the written value on a write.
- R3: Writing 0 to a flag bit (3..0) clears it, and writing 1 to a flag bit leaves it unchanged. When a hardware event and a write touch the same bit in the same cycle, the hardware event decides the bit.
- R4: When `ev_setup` is high on a control endpoint, the next word is 8'h04, whatever the write port carries. On the other endpoint types `ev_setup` has no effect.
- R5: `ev_out` sets bit 1 on every endpoint type. While bit 1 is set on a non-isochronous endpoint with bit 5 clear, an OUT token (`tok_kind` 00) gets NAK. `hs` encodes 00 ACK, 01 NAK, 10 STALL and 11 no handshake.
- R6: A SETUP token (`tok_kind` 10) gets ACK on a control endpoint, even when bit 1 or bit 5 is set. On bulk and interrupt endpoints a SETUP token gets no handshake. The idle code (`tok_kind` 11) always gets no handshake.
- R7: `in_avail` equals bit 4. On a non-isochronous endpoint with bit 5 clear, an IN token (`tok_kind` 01) gets NAK while bit 4 is clear and ACK while it is set. An OUT token with bit 1 clear gets ACK.
- R8: On isochronous endpoints `ev_in_sent` clears bit 4 and sets bit 0, and `ev_in_ack` has no effect. On the other types `ev_in_ack` does this, and `ev_in_sent` has no effect. The hardware clear of bit 4 wins over a write of 1 in the same cycle.
- R9: On non-isochronous endpoints `ev_stall_sent` sets bit 3 only while bit 5 is set. `ev_crc_err` has no effect on these endpoints.
- R10: On isochronous endpoints `ev_crc_err` sets bit 3, and `ev_out` clears it. If both arrive in the same cycle, bit 3 ends up set. `ev_stall_sent` has no effect on these endpoints.
- R11: On a non-isochronous endpoint with bit 5 set, OUT and IN tokens get STALL, overriding any NAK condition.
- R12: An isochronous endpoint returns no handshake for any token.
- R13: `irq` is high exactly when `irq_en` is high and at least one of bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current status word |
| irq_en | input | 1 | Endpoint interrupt enable |
| ep_type | input | 2 | Endpoint transfer type |
| tok_kind | input | 2 | Kind of token the handshake is chosen for |
| ev_setup | input | 1 | Valid SETUP packet received |
| ev_out | input | 1 | Good OUT data packet received |
| ev_in_sent | input | 1 | IN packet transmitted |
| ev_in_ack | input | 1 | Host acknowledged the IN packet |
| ev_crc_err | input | 1 | Received data packet had a CRC error |
| ev_stall_sent | input | 1 | A STALL handshake went out |
| hs | output | 2 | Handshake for the current token |
| in_avail | output | 1 | An IN packet is offered |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The block has no tunable parameters; its word width and bit positions are fixed package constants. The bench therefore builds it as it is. The bench walks all four endpoint types against all four token codes, which reaches every branch of the handshake priority and every per-type flag rule. Directed steps cover the case where a write and an event arrive in the same cycle, and the SETUP wipe. A long stretch of random strobes, writes and types is then compared against a reference model written from the requirements.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  localparam int WORD_W  = 8;
  localparam int FLAG_N  = 4;

  // bit positions of the status word
  localparam int P_DIR   = 7;
  localparam int P_RSV   = 6;
  localparam int P_STREQ = 5;
  localparam int P_TXRDY = 4;
  localparam int P_SCF   = 3;
  localparam int P_SETUP = 2;
  localparam int P_OUTF  = 1;
  localparam int P_TXDN  = 0;

  localparam logic [WORD_W-1:0] RW_MASK =
    (WORD_W'(1) << P_DIR) | (WORD_W'(1) << P_STREQ) | (WORD_W'(1) << P_TXRDY);
  localparam logic [WORD_W-1:0] SETUP_WORD = WORD_W'(1) << P_SETUP;

  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_BULK = 2'b01,
    EP_INTR = 2'b10,
    EP_ISO  = 2'b11
  } ep_kind_t;

  typedef enum logic [1:0] {
    TK_OUT   = 2'b00,
    TK_IN    = 2'b01,
    TK_SETUP = 2'b10,
    TK_IDLE  = 2'b11
  } tok_t;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_NONE  = 2'b11
  } hs_t;

  // one flag bit: hardware set beats hardware clear beats software clear
  function automatic logic flag_step(logic cur, logic sw_clr, logic hw_set, logic hw_clr);
    if (hw_set)      return 1'b1;
    else if (hw_clr) return 1'b0;
    else if (sw_clr) return 1'b0;
    else             return cur;
  endfunction

  // handshake choice for one token
  function automatic hs_t choose_hs(ep_kind_t kind, tok_t tok, logic stall_req,
                                    logic out_pend, logic tx_ready);
    if (kind == EP_ISO || tok == TK_IDLE) return HS_NONE;
    if (tok == TK_SETUP)                  return (kind == EP_CTRL) ? HS_ACK : HS_NONE;
    if (stall_req)                        return HS_STALL;
    if (tok == TK_OUT && out_pend)        return HS_NAK;
    if (tok == TK_IN && !tx_ready)        return HS_NAK;
    return HS_ACK;
  endfunction

endpackage

// File: rtl/ep_event_decode.sv
module ep_event_decode
  import usb_ep_pkg::*;
(
  input  logic [1:0] ep_type,
  input  logic       stall_req,
  input  logic       ev_setup,
  input  logic       ev_out,
  input  logic       ev_in_sent,
  input  logic       ev_in_ack,
  input  logic       ev_crc_err,
  input  logic       ev_stall_sent,
  output logic       setup_hit,
  output logic       out_hit,
  output logic       txdone_hit,
  output logic       scf_set,
  output logic       scf_clr
);

  ep_kind_t kind;
  logic     is_iso;

  always_comb begin
    kind       = ep_kind_t'(ep_type);
    is_iso     = (kind == EP_ISO);
    setup_hit  = ev_setup && (kind == EP_CTRL);
    out_hit    = ev_out;
    txdone_hit = is_iso ? ev_in_sent : ev_in_ack;
    if (is_iso) begin
      scf_set = ev_crc_err;
      scf_clr = ev_out;
    end else begin
      scf_set = ev_stall_sent && stall_req;
      scf_clr = 1'b0;
    end
  end

endmodule

// File: rtl/ep_reg_next.sv
module ep_reg_next
  import usb_ep_pkg::*;
(
  input  logic [WORD_W-1:0] cur,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              setup_hit,
  input  logic              out_hit,
  input  logic              txdone_hit,
  input  logic              scf_set,
  input  logic              scf_clr,
  output logic [WORD_W-1:0] nxt
);

  logic [WORD_W-1:0] ctrl_part;
  logic [FLAG_N-1:0] sw_clr;
  logic [FLAG_N-1:0] hw_set;
  logic [FLAG_N-1:0] hw_clr;
  logic [FLAG_N-1:0] flags_nxt;

  always_comb begin
    ctrl_part = wr_en ? (wr_data & RW_MASK) : (cur & RW_MASK);
    if (txdone_hit) ctrl_part[P_TXRDY] = 1'b0;
    sw_clr = wr_en ? ~wr_data[FLAG_N-1:0] : '0;
    hw_set = '0;
    hw_clr = '0;
    hw_set[P_SCF]  = scf_set;
    hw_clr[P_SCF]  = scf_clr;
    hw_set[P_OUTF] = out_hit;
    hw_set[P_TXDN] = txdone_hit;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign flags_nxt[i] = flag_step(cur[i], sw_clr[i], hw_set[i], hw_clr[i]);
  end

  always_comb begin
    if (setup_hit) nxt = SETUP_WORD;
    else           nxt = {ctrl_part[WORD_W-1:FLAG_N], flags_nxt};
  end

endmodule

// File: rtl/ep_handshake.sv
module ep_handshake
  import usb_ep_pkg::*;
(
  input  logic [1:0] ep_type,
  input  logic [1:0] tok_kind,
  input  logic       stall_req,
  input  logic       out_pend,
  input  logic       tx_ready,
  output logic [1:0] hs
);

  hs_t pick;

  always_comb begin
    pick = choose_hs(ep_kind_t'(ep_type), tok_t'(tok_kind), stall_req, out_pend, tx_ready);
    hs   = pick;
  end

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              irq_en,
  input  logic [1:0]        ep_type,
  input  logic [1:0]        tok_kind,
  input  logic              ev_setup,
  input  logic              ev_out,
  input  logic              ev_in_sent,
  input  logic              ev_in_ack,
  input  logic              ev_crc_err,
  input  logic              ev_stall_sent,
  output logic [1:0]        hs,
  output logic              in_avail,
  output logic              irq
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  // named internal events, visible to the checker
  logic setup_hit;
  logic out_hit;
  logic txdone_hit;
  logic scf_set;
  logic scf_clr;

  ep_event_decode u_dec (
    .ep_type      (ep_type),
    .stall_req    (word_q[P_STREQ]),
    .ev_setup     (ev_setup),
    .ev_out       (ev_out),
    .ev_in_sent   (ev_in_sent),
    .ev_in_ack    (ev_in_ack),
    .ev_crc_err   (ev_crc_err),
    .ev_stall_sent(ev_stall_sent),
    .setup_hit    (setup_hit),
    .out_hit      (out_hit),
    .txdone_hit   (txdone_hit),
    .scf_set      (scf_set),
    .scf_clr      (scf_clr)
  );

  ep_reg_next u_nxt (
    .cur       (word_q),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .setup_hit (setup_hit),
    .out_hit   (out_hit),
    .txdone_hit(txdone_hit),
    .scf_set   (scf_set),
    .scf_clr   (scf_clr),
    .nxt       (word_d)
  );

  ep_handshake u_hs (
    .ep_type  (ep_type),
    .tok_kind (tok_kind),
    .stall_req(word_q[P_STREQ]),
    .out_pend (word_q[P_OUTF]),
    .tx_ready (word_q[P_TXRDY]),
    .hs       (hs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign rd_data  = word_q;
  assign in_avail = word_q[P_TXRDY];
  assign irq      = irq_en && (|word_q[FLAG_N-1:0]);

endmodule

// File: rtl/usb_ep_ctrl_chk.sv
module usb_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ep_type,
  input logic [1:0] tok_kind,
  input logic       irq_en,
  input logic [7:0] rd_data,
  input logic [1:0] hs,
  input logic       in_avail,
  input logic       irq,
  input logic       setup_hit,
  input logic       txdone_hit
);

  // R4
  setup_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_hit |=> rd_data == 8'h04);

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] == 1'b0);

  // R13
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R13
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rd_data[1]) |-> irq);

  // R12
  iso_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_type == 2'b11) |-> hs == 2'b11);

  // R5
  out_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_type != 2'b11 && rd_data[1] && !rd_data[5] && tok_kind == 2'b00) |-> hs == 2'b01);

  // R11
  stall_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_type != 2'b11 && rd_data[5] && !tok_kind[1]) |-> hs == 2'b10);

  // R8
  txdone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txdone_hit && !setup_hit) |=> (rd_data[0] && !rd_data[4]));

  // R7
  avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_avail == rd_data[4]);

endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ep_type   (ep_type),
  .tok_kind  (tok_kind),
  .irq_en    (irq_en),
  .rd_data   (rd_data),
  .hs        (hs),
  .in_avail  (in_avail),
  .irq       (irq),
  .setup_hit (setup_hit),
  .txdone_hit(txdone_hit)
);

// File: tb/usb_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_ep_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_en = 1'b0;
  logic [1:0] ep_type = 2'b01;
  logic [1:0] tok_kind = 2'b11;
  logic       ev_setup = 1'b0, ev_out = 1'b0, ev_in_sent = 1'b0;
  logic       ev_in_ack = 1'b0, ev_crc_err = 1'b0, ev_stall_sent = 1'b0;
  logic [1:0] hs;
  logic       in_avail;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_ep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_en(irq_en), .ep_type(ep_type), .tok_kind(tok_kind),
    .ev_setup(ev_setup), .ev_out(ev_out), .ev_in_sent(ev_in_sent),
    .ev_in_ack(ev_in_ack), .ev_crc_err(ev_crc_err), .ev_stall_sent(ev_stall_sent),
    .hs(hs), .in_avail(in_avail), .irq(irq)
  );

  typedef struct {
    string    tag;
    bit [7:0] rd;
    bit [1:0] hs;
    bit       irq;
    bit       av;
  } item_t;

  item_t sb[$];
  bit [7:0] mdl = 8'h00;

  // reference rules, restated from the requirements
  function automatic bit [7:0] ref_next(bit [7:0] r, bit [1:0] typ, bit wen, bit [7:0] wd,
                                        bit [5:0] ev);
    bit [7:0] n;
    bit su = ev[5], ou = ev[4], snt = ev[3], ack = ev[2], crc = ev[1], stl = ev[0];
    bit iso = (typ == 2'b11);
    if (su && typ == 2'b00) return 8'h04;
    n = r;
    if (wen) begin
      n[7] = wd[7];
      n[5] = wd[5];
      n[4] = wd[4];
      for (int i = 0; i < 4; i++) if (!wd[i]) n[i] = 1'b0;
    end
    if ((iso && snt) || (!iso && ack)) begin
      n[4] = 1'b0;
      n[0] = 1'b1;
    end
    if (ou) n[1] = 1'b1;
    if (iso) begin
      if (ou)  n[3] = 1'b0;
      if (crc) n[3] = 1'b1;
    end else if (stl && r[5]) begin
      n[3] = 1'b1;
    end
    return n;
  endfunction

  function automatic bit [1:0] ref_hs(bit [7:0] r, bit [1:0] typ, bit [1:0] tok);
    if (typ == 2'b11 || tok == 2'b11) return 2'b11;
    if (tok == 2'b10) return (typ == 2'b00) ? 2'b00 : 2'b11;
    if (r[5]) return 2'b10;
    if (tok == 2'b00 && r[1]) return 2'b01;
    if (tok == 2'b01 && !r[4]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(string tag, bit wen, bit [7:0] wd, bit ien, bit [1:0] typ,
                       bit [1:0] tok, bit [5:0] ev);
    item_t it;
    @(negedge clk);
    wr_en = wen; wr_data = wd; irq_en = ien; ep_type = typ; tok_kind = tok;
    {ev_setup, ev_out, ev_in_sent, ev_in_ack, ev_crc_err, ev_stall_sent} = ev;
    mdl = ref_next(mdl, typ, wen, wd, ev);
    it.tag = tag;
    it.rd  = mdl;
    it.hs  = ref_hs(mdl, typ, tok);
    it.irq = ien && (mdl[3:0] != 4'h0);
    it.av  = mdl[4];
    sb.push_back(it);
  endtask

  // monitor: one expected item per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (rd_data !== it.rd || hs !== it.hs || irq !== it.irq || in_avail !== it.av) begin
          bad++;
          $display("FAIL %s actual rd=%h hs=%0d irq=%0b av=%0b expected rd=%h hs=%0d irq=%0b av=%0b",
                   it.tag, rd_data, hs, irq, in_avail, it.rd, it.hs, it.irq, it.av);
        end
      end
    end
  end

  // event bit order: {setup, out, in_sent, in_ack, crc_err, stall_sent}
  localparam bit [5:0] E0 = 6'b000000, SU = 6'b100000, OU = 6'b010000, SN = 6'b001000;
  localparam bit [5:0] AK = 6'b000100, CR = 6'b000010, ST = 6'b000001;

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rd_data !== 8'h00 || irq !== 1'b0 || in_avail !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual rd=%h irq=%0b av=%0b expected rd=00 irq=0 av=0",
               rd_data, irq, in_avail);
    end
    rst_n = 1'b1;
    drive("R1", 0, 8'h00, 0, 2'b01, 2'b11, E0);
    // writes: control bits stored, flags and reserved ignore 1
    drive("R2", 1, 8'hFF, 0, 2'b01, 2'b01, E0);
    drive("R11", 0, 8'h00, 0, 2'b01, 2'b00, E0);
    drive("R11", 0, 8'h00, 0, 2'b10, 2'b01, E0);
    drive("R6", 0, 8'h00, 0, 2'b00, 2'b10, E0);
    drive("R6", 0, 8'h00, 0, 2'b01, 2'b10, E0);
    drive("R2", 1, 8'h00, 0, 2'b01, 2'b01, E0);
    drive("R7", 0, 8'h00, 0, 2'b01, 2'b00, E0);
    // OUT pending and NAK
    drive("R5", 0, 8'h00, 1, 2'b01, 2'b00, OU);
    drive("R13", 0, 8'h00, 0, 2'b01, 2'b00, E0);
    drive("R6", 0, 8'h00, 1, 2'b00, 2'b10, E0);
    drive("R3", 1, 8'h02, 1, 2'b01, 2'b00, E0);
    drive("R3", 1, 8'h00, 1, 2'b01, 2'b00, OU);
    drive("R3", 1, 8'h00, 1, 2'b01, 2'b00, E0);
    // SETUP wipe
    drive("R4", 1, 8'hB0, 1, 2'b00, 2'b11, E0);
    drive("R4", 1, 8'hFF, 1, 2'b00, 2'b10, SU | OU | AK);
    drive("R4", 1, 8'hA0, 1, 2'b01, 2'b00, SU);
    drive("R4", 1, 8'h00, 0, 2'b10, 2'b11, E0);
    // IN completion, non-isochronous
    drive("R7", 1, 8'h10, 0, 2'b01, 2'b01, E0);
    drive("R8", 0, 8'h00, 0, 2'b01, 2'b01, SN);
    drive("R8", 0, 8'h00, 1, 2'b01, 2'b01, AK);
    drive("R8", 1, 8'h10, 1, 2'b10, 2'b01, AK);
    drive("R9", 1, 8'h00, 0, 2'b01, 2'b11, ST | CR);
    drive("R9", 1, 8'h20, 0, 2'b01, 2'b00, E0);
    drive("R9", 0, 8'h00, 1, 2'b01, 2'b00, ST);
    // isochronous rules
    drive("R12", 1, 8'h10, 0, 2'b11, 2'b01, E0);
    drive("R8", 0, 8'h00, 0, 2'b11, 2'b00, AK | ST);
    drive("R8", 0, 8'h00, 0, 2'b11, 2'b10, SN);
    drive("R10", 1, 8'h00, 1, 2'b11, 2'b00, CR);
    drive("R10", 0, 8'h00, 1, 2'b11, 2'b00, OU);
    drive("R10", 0, 8'h00, 1, 2'b11, 2'b01, OU | CR);
    drive("R12", 1, 8'h20, 0, 2'b11, 2'b00, E0);
    drive("R3", 1, 8'h20, 1, 2'b11, 2'b01, E0);
    drive("R13", 1, 8'h00, 1, 2'b01, 2'b11, E0);
    // random stretch against the model
    for (int k = 0; k < 600; k++) begin
      bit [5:0] ev;
      for (int b = 0; b < 6; b++) ev[b] = (($urandom % 5) == 0);
      drive("R3", (($urandom % 4) == 0), 8'($urandom), 1'($urandom), 2'($urandom),
            2'($urandom), ev);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule